// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the software-visible control and status state of a 64-channel DMA controller. It sits on a simple 32-bit register bus and owns five per-channel bit vectors: request enable, error-interrupt enable, interrupt flag, error flag and a live view of the hardware request lines. Each vector is 64 bits wide and is read as two words. The upper word holds channels 63 to 32 and the lower word holds channels 31 to 0.

Software usually changes one channel at a time. It writes a channel number into one of eight byte-wide command registers. Each command sets or clears one bit, or fires a one-cycle pulse toward the channel engines (start a channel, clear its done state). Software can also write the vectors as whole words. The two flag vectors are write-one-to-clear. A global error status register keeps the first reported error: a valid flag, the failing channel number and one bit per error cause.

The channel engines feed the block with per-channel interrupt requests, error events and hardware request levels. They receive the request enables, the start and done-clear pulses, two aggregate interrupt lines and three arbitration/clocking configuration bits.

Top module: `dmacsr_top`

## Requirements
- R1: After reset, every vector, the control register and the error status register read zero, and the pulse, enable, interrupt and configuration outputs are low.
- R2: The control word at 0x00 stores only bit 31 (clock gating enable), bit 3 (round-robin group arbitration) and bit 2 (round-robin channel arbitration). These drive `cfg_clk_gate`, `cfg_rr_group` and `cfg_rr_chan`. All other bits read zero.
- R3: Request enable sits at 0x08 (upper, channels 63..32) and 0x0C (lower, channels 31..0). Error-interrupt enable sits at 0x10 and 0x14 in the same way. Both are read/write, and byte enable k writes bits 8k+7..8k only. `req_en` presents the request enable vector.
- R4: The byte commands are selected by byte enables. Word 0x18: lane 0 sets a request enable, lane 1 clears a request enable, lane 2 sets an error-interrupt enable, lane 3 clears an error-interrupt enable. Word 0x1C: lane 0 clears an interrupt flag, lane 1 clears an error flag, lane 2 starts a channel, lane 3 clears done. Lane k carries data bits 8k+7..8k. Bits 5..0 give the channel, bits 7..6 are ignored, and only that channel's bit changes.
- R5: A start or clear-done command drives exactly bit N of `start_pulse` or `done_clr_pulse` high for the one cycle after the write, and low again after that.
- R6: Interrupt flags (0x20 upper, 0x24 lower) and error flags (0x28 upper, 0x2C lower) are write-one-to-clear. A written 0 leaves the flag unchanged.
- R7: A high `done_int[N]` sets interrupt flag N, and it wins over a clear of that flag in the same cycle. `int_irq` is high while any interrupt flag is set.
- R8: An error event on channel N sets error flag N, and so raises `err_irq`, only while error-interrupt enable N is set.
- R9: When its valid flag is clear, the error status word at 0x04 captures an error event. It records bit 31 as valid, bits 13..8 as the channel, and cause bits 15, 14 and 7..0 from `err_evt_cause`. Other cause bits are dropped. Later events leave it unchanged while valid is set.
- R10: Clearing the error flag of the recorded channel clears the whole error status word. This applies to both the command and the write-one-to-clear path. Clearing any other channel leaves the word unchanged.
- R11: The hardware request status at 0x30 (upper) and 0x34 (lower) reads `hw_req` directly, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte enables, lane k = data bits 8k+7..8k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| hw_req | input | 64 | Hardware request levels per channel |
| done_int | input | 64 | Per-channel interrupt set strobes |
| err_evt | input | 1 | Error event strobe |
| err_evt_ch | input | 6 | Channel of the error event |
| err_evt_cause | input | 16 | Cause bits of the error event |
| req_en | output | 64 | Request enable vector |
| start_pulse | output | 64 | One-cycle channel start pulses |
| done_clr_pulse | output | 64 | One-cycle done-clear pulses |
| int_irq | output | 1 | Any interrupt flag set |
| err_irq | output | 1 | Any error flag set |
| cfg_clk_gate | output | 1 | Clock gating enable |
| cfg_rr_group | output | 1 | Round-robin group arbitration |
| cfg_rr_chan | output | 1 | Round-robin channel arbitration |

## Verification
The bench targets these corner cases:
- A command byte with bits 7..6 set. A design that decoded all eight bits would address a nonexistent channel and miss bit 5.
- An interrupt set and a clear of the same channel in one cycle. A design that let the clear win would drop the interrupt.
- A write of zeros to a flag word. A design with plain read/write flags would wipe all pending flags.
- An error event on a channel whose error interrupt is disabled, which must still fill the status word. Also a second error that must not overwrite the first.
- A clear of an unrelated channel's error, which must leave the status valid.
- Partial byte-enable writes. A design that ignored lanes would corrupt the neighbouring bytes.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int NCH      = 64;
    localparam int CH_W     = $clog2(NCH);
    localparam int DW       = 32;
    localparam int AW       = 8;
    localparam int BE_W     = DW / 8;
    localparam int CMD_N    = 8;

    localparam logic [AW-1:0] A_CTRL    = 8'h00;
    localparam logic [AW-1:0] A_ESTAT   = 8'h04;
    localparam logic [AW-1:0] A_RQEN_HI = 8'h08;
    localparam logic [AW-1:0] A_RQEN_LO = 8'h0C;
    localparam logic [AW-1:0] A_EIEN_HI = 8'h10;
    localparam logic [AW-1:0] A_EIEN_LO = 8'h14;
    localparam logic [AW-1:0] A_CMD0    = 8'h18;
    localparam logic [AW-1:0] A_CMD1    = 8'h1C;
    localparam logic [AW-1:0] A_INT_HI  = 8'h20;
    localparam logic [AW-1:0] A_INT_LO  = 8'h24;
    localparam logic [AW-1:0] A_ERR_HI  = 8'h28;
    localparam logic [AW-1:0] A_ERR_LO  = 8'h2C;
    localparam logic [AW-1:0] A_HREQ_HI = 8'h30;
    localparam logic [AW-1:0] A_HREQ_LO = 8'h34;

    localparam logic [15:0] CAUSE_KEEP = 16'hC0FF;

    typedef enum logic [2:0] {
        CMD_SET_RQ    = 3'd0,
        CMD_CLR_RQ    = 3'd1,
        CMD_SET_EI    = 3'd2,
        CMD_CLR_EI    = 3'd3,
        CMD_CLR_INT   = 3'd4,
        CMD_CLR_ERR   = 3'd5,
        CMD_SET_START = 3'd6,
        CMD_CLR_DONE  = 3'd7
    } cmd_idx_e;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
    } cmd_t;

    typedef struct packed {
        logic ctrl;
        logic rqen_hi;
        logic rqen_lo;
        logic eien_hi;
        logic eien_lo;
        logic int_hi;
        logic int_lo;
        logic err_hi;
        logic err_lo;
    } word_wr_t;

    typedef struct packed {
        logic        vld;
        logic [14:0] rsvd;
        logic [1:0]  prio_err;
        logic [5:0]  ch;
        logic [7:0]  xfer_err;
    } estat_t;

    function automatic logic [DW-1:0] be_to_mask(input logic [BE_W-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < BE_W; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [NCH-1:0] ch_onehot(input cmd_t c);
        logic [NCH-1:0] v;
        v = '0;
        if (c.valid) v[c.ch] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
    import dmacsr_pkg::*;
(
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [BE_W-1:0]       bus_be,
    input  logic [DW-1:0]         bus_wdata,
    output word_wr_t              wwr,
    output logic [DW-1:0]         wmask,
    output cmd_t [CMD_N-1:0]      cmds
);

    logic wr_en;
    assign wr_en = bus_sel & bus_wr;
    assign wmask = be_to_mask(bus_be);

    always_comb begin
        wwr         = '0;
        wwr.ctrl    = wr_en && (bus_addr == A_CTRL);
        wwr.rqen_hi = wr_en && (bus_addr == A_RQEN_HI);
        wwr.rqen_lo = wr_en && (bus_addr == A_RQEN_LO);
        wwr.eien_hi = wr_en && (bus_addr == A_EIEN_HI);
        wwr.eien_lo = wr_en && (bus_addr == A_EIEN_LO);
        wwr.int_hi  = wr_en && (bus_addr == A_INT_HI);
        wwr.int_lo  = wr_en && (bus_addr == A_INT_LO);
        wwr.err_hi  = wr_en && (bus_addr == A_ERR_HI);
        wwr.err_lo  = wr_en && (bus_addr == A_ERR_LO);
    end

    for (genvar k = 0; k < CMD_N; k++) begin : g_cmd
        localparam logic [AW-1:0] WADDR = (k < BE_W) ? A_CMD0 : A_CMD1;
        localparam int LANE = k % BE_W;
        assign cmds[k].valid = wr_en && (bus_addr == WADDR) && bus_be[LANE];
        assign cmds[k].ch    = bus_wdata[8*LANE +: CH_W];
    end

endmodule

// File: rtl/dmacsr_vec.sv
module dmacsr_vec
    import dmacsr_pkg::*;
#(
    parameter bit W1C = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  cmd_t           set_cmd,
    input  cmd_t           clr_cmd,
    input  logic           wr_hi,
    input  logic           wr_lo,
    input  logic [DW-1:0]  wdata,
    input  logic [DW-1:0]  wmask,
    input  logic [NCH-1:0] evt_set,
    output logic [NCH-1:0] q
);

    logic [NCH-1:0] word_sel;
    logic [NCH-1:0] wbits;
    logic [NCH-1:0] mask2;
    logic [NCH-1:0] after_word;
    logic [NCH-1:0] q_d;

    assign word_sel = {{DW{wr_hi}}, {DW{wr_lo}}};
    assign wbits    = {2{wdata & wmask}};
    assign mask2    = {2{wmask}};

    if (W1C) begin : g_w1c
        assign after_word = q & ~(wbits & word_sel);
    end else begin : g_rw
        assign after_word = (q & ~(mask2 & word_sel)) | (wbits & word_sel);
    end

    always_comb begin
        q_d = after_word;
        if (clr_cmd.valid) q_d[clr_cmd.ch] = 1'b0;
        if (set_cmd.valid) q_d[set_cmd.ch] = 1'b1;
        q_d = q_d | evt_set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_d;
    end

    assert_set_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        set_cmd.valid |=> q[$past(set_cmd.ch)]);

    assert_clr_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_cmd.valid && !(set_cmd.valid && set_cmd.ch == clr_cmd.ch) && !evt_set[clr_cmd.ch])
        |=> !q[$past(clr_cmd.ch)]);

    assert_no_spurious_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_hi && !wr_lo && !clr_cmd.valid) |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/dmacsr_errstat.sv
module dmacsr_errstat
    import dmacsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            evt,
    input  logic [CH_W-1:0] evt_ch,
    input  logic [15:0]     evt_cause,
    input  logic            clr_hit,
    output estat_t          es
);

    estat_t         cap;
    logic [15:0]    kept;

    assign kept = evt_cause & CAUSE_KEEP;

    always_comb begin
        cap          = '0;
        cap.vld      = 1'b1;
        cap.ch       = evt_ch;
        cap.prio_err = kept[15:14];
        cap.xfer_err = kept[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                 es <= '0;
        else if (es.vld) begin
            if (clr_hit)         es <= '0;
        end else if (evt)        es <= cap;
    end

    assert_hold_first_R9: assert property (@(posedge clk) disable iff (rst)
        (es.vld && !clr_hit) |=> $stable(es));

    assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (!es.vld && evt) |=> (es.vld && es.ch == $past(evt_ch)));

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (es.vld && clr_hit) |=> !es.vld);

endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
    import dmacsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [3:0]      bus_be,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [63:0]     hw_req,
    input  logic [63:0]     done_int,
    input  logic            err_evt,
    input  logic [5:0]      err_evt_ch,
    input  logic [15:0]     err_evt_cause,
    output logic [63:0]     req_en,
    output logic [63:0]     start_pulse,
    output logic [63:0]     done_clr_pulse,
    output logic            int_irq,
    output logic            err_irq,
    output logic            cfg_clk_gate,
    output logic            cfg_rr_group,
    output logic            cfg_rr_chan
);

    word_wr_t          wwr;
    logic [DW-1:0]     wmask;
    cmd_t [CMD_N-1:0]  cmds;
    logic [NCH-1:0]    ei_en;
    logic [NCH-1:0]    int_flag;
    logic [NCH-1:0]    err_flag;
    logic [NCH-1:0]    err_set;
    logic [NCH-1:0]    err_w1c;
    logic              es_clr_hit;
    estat_t            es;
    cmd_t              no_cmd;

    assign no_cmd = '0;

    dmacsr_decode u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .wwr       (wwr),
        .wmask     (wmask),
        .cmds      (cmds)
    );

    // control register: three live bits
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_clk_gate <= 1'b0;
            cfg_rr_group <= 1'b0;
            cfg_rr_chan  <= 1'b0;
        end else if (wwr.ctrl) begin
            if (bus_be[3]) cfg_clk_gate <= bus_wdata[31];
            if (bus_be[0]) begin
                cfg_rr_group <= bus_wdata[3];
                cfg_rr_chan  <= bus_wdata[2];
            end
        end
    end

    dmacsr_vec #(.W1C(1'b0)) u_rqen (
        .clk(clk), .rst(rst),
        .set_cmd(cmds[CMD_SET_RQ]), .clr_cmd(cmds[CMD_CLR_RQ]),
        .wr_hi(wwr.rqen_hi), .wr_lo(wwr.rqen_lo),
        .wdata(bus_wdata), .wmask(wmask),
        .evt_set('0), .q(req_en)
    );

    dmacsr_vec #(.W1C(1'b0)) u_eien (
        .clk(clk), .rst(rst),
        .set_cmd(cmds[CMD_SET_EI]), .clr_cmd(cmds[CMD_CLR_EI]),
        .wr_hi(wwr.eien_hi), .wr_lo(wwr.eien_lo),
        .wdata(bus_wdata), .wmask(wmask),
        .evt_set('0), .q(ei_en)
    );

    dmacsr_vec #(.W1C(1'b1)) u_int (
        .clk(clk), .rst(rst),
        .set_cmd(no_cmd), .clr_cmd(cmds[CMD_CLR_INT]),
        .wr_hi(wwr.int_hi), .wr_lo(wwr.int_lo),
        .wdata(bus_wdata), .wmask(wmask),
        .evt_set(done_int), .q(int_flag)
    );

    always_comb begin
        err_set = '0;
        if (err_evt && ei_en[err_evt_ch]) err_set[err_evt_ch] = 1'b1;
    end

    dmacsr_vec #(.W1C(1'b1)) u_err (
        .clk(clk), .rst(rst),
        .set_cmd(no_cmd), .clr_cmd(cmds[CMD_CLR_ERR]),
        .wr_hi(wwr.err_hi), .wr_lo(wwr.err_lo),
        .wdata(bus_wdata), .wmask(wmask),
        .evt_set(err_set), .q(err_flag)
    );

    assign err_w1c = {(wwr.err_hi ? (bus_wdata & wmask) : '0),
                      (wwr.err_lo ? (bus_wdata & wmask) : '0)};

    assign es_clr_hit = es.vld &&
        ((cmds[CMD_CLR_ERR].valid && cmds[CMD_CLR_ERR].ch == es.ch) || err_w1c[es.ch]);

    dmacsr_errstat u_es (
        .clk       (clk),
        .rst       (rst),
        .evt       (err_evt),
        .evt_ch    (err_evt_ch),
        .evt_cause (err_evt_cause),
        .clr_hit   (es_clr_hit),
        .es        (es)
    );

    // one-cycle pulses toward the channel engines
    always_ff @(posedge clk) begin
        if (rst) begin
            start_pulse    <= '0;
            done_clr_pulse <= '0;
        end else begin
            start_pulse    <= ch_onehot(cmds[CMD_SET_START]);
            done_clr_pulse <= ch_onehot(cmds[CMD_CLR_DONE]);
        end
    end

    assign int_irq = |int_flag;
    assign err_irq = |err_flag;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_CTRL:    bus_rdata = {cfg_clk_gate, 27'd0, cfg_rr_group, cfg_rr_chan, 2'd0};
                A_ESTAT:   bus_rdata = es;
                A_RQEN_HI: bus_rdata = req_en[63:32];
                A_RQEN_LO: bus_rdata = req_en[31:0];
                A_EIEN_HI: bus_rdata = ei_en[63:32];
                A_EIEN_LO: bus_rdata = ei_en[31:0];
                A_INT_HI:  bus_rdata = int_flag[63:32];
                A_INT_LO:  bus_rdata = int_flag[31:0];
                A_ERR_HI:  bus_rdata = err_flag[63:32];
                A_ERR_LO:  bus_rdata = err_flag[31:0];
                A_HREQ_HI: bus_rdata = hw_req[63:32];
                A_HREQ_LO: bus_rdata = hw_req[31:0];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_start_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_pulse) && $onehot0(done_clr_pulse));

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wwr.ctrl && bus_be[0]) |=> (cfg_rr_chan == $past(bus_wdata[2])));

    assert_err_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (err_evt && !ei_en[err_evt_ch] && !err_flag[err_evt_ch]) |=> !err_flag[$past(err_evt_ch)]);

endmodule

// File: tb/test_dmacsr_top.sv
`timescale 1ns/1ps
module test_dmacsr_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] hw_req = '0, done_int = '0;
    logic        err_evt = 1'b0;
    logic [5:0]  err_evt_ch = '0;
    logic [15:0] err_evt_cause = '0;
    logic [63:0] req_en, start_pulse, done_clr_pulse;
    logic        int_irq, err_irq, cfg_clk_gate, cfg_rr_group, cfg_rr_chan;

    always #10 clk = ~clk;

    dmacsr_top i_dmacsr_top (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_req(hw_req), .done_int(done_int),
        .err_evt(err_evt), .err_evt_ch(err_evt_ch), .err_evt_cause(err_evt_cause),
        .req_en(req_en), .start_pulse(start_pulse), .done_clr_pulse(done_clr_pulse),
        .int_irq(int_irq), .err_irq(err_irq),
        .cfg_clk_gate(cfg_clk_gate), .cfg_rr_group(cfg_rr_group), .cfg_rr_chan(cfg_rr_chan)
    );

    // kinds: 0 read data, 1 start pulses, 2 done-clear pulses, 3 req_en,
    //        4 {int_irq,err_irq}, 5 {clk_gate,rr_group,rr_chan}
    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    function automatic logic [63:0] observe(input int kind);
        case (kind)
            0: return {32'd0, bus_rdata};
            1: return start_pulse;
            2: return done_clr_pulse;
            3: return req_en;
            4: return {62'd0, int_irq, err_irq};
            default: return {61'd0, cfg_clk_gate, cfg_rr_group, cfg_rr_chan};
        endcase
    endfunction

    // monitor: compares queued expectations after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it  = sb.pop_front();
                act = observe(it.kind);
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    function automatic void push(input int kind, input logic [63:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic wr_pulse(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                            input int kind, input logic [63:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        push(kind, exp, tag);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
        push(kind, 64'd0, {tag, " pulse ends"});
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        push(0, {32'd0, exp}, tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [63:0] exp, input string tag);
        @(negedge clk);
        push(kind, exp, tag);
    endtask

    task automatic ev_done(input logic [63:0] m);
        @(negedge clk); done_int = m;
        @(negedge clk); done_int = '0;
    endtask

    task automatic ev_err(input logic [5:0] ch, input logic [15:0] cause);
        @(negedge clk); err_evt = 1'b1; err_evt_ch = ch; err_evt_cause = cause;
        @(negedge clk); err_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h04, 32'h0, "R1 estat");
        rd(8'h24, 32'h0, "R1 int lo");
        chk(3, 64'h0, "R1 req_en");
        chk(4, 64'h0, "R1 irqs");
        chk(5, 64'h0, "R1 cfg");

        // R2 control register
        wr(8'h00, 4'hF, 32'hFFFF_FFFF);
        rd(8'h00, 32'h8000_000C, "R2 ctrl readback");
        chk(5, 64'h7, "R2 cfg outputs");
        wr(8'h00, 4'hF, 32'h0);
        rd(8'h00, 32'h0, "R2 ctrl cleared");

        // R3 word writes with byte enables
        wr(8'h0C, 4'b0011, 32'hA5A5_0F0F);
        rd(8'h0C, 32'h0000_0F0F, "R3 partial lanes");
        wr(8'h08, 4'hF, 32'h1234_5678);
        rd(8'h08, 32'h1234_5678, "R3 rqen hi");

        // R4 byte commands
        wr(8'h18, 4'b0010, 32'd36 << 8);
        rd(8'h08, 32'h1234_5668, "R4 clear rqen ch36");
        wr(8'h18, 4'b0001, 32'h0000_0045);
        rd(8'h0C, 32'h0000_0F2F, "R4 set rqen ch5 upper bits ignored");
        chk(3, 64'h1234_5668_0000_0F2F, "R3 req_en output");
        wr(8'h18, 4'b0100, 32'd63 << 16);
        rd(8'h10, 32'h8000_0000, "R4 set eien ch63");
        wr(8'h18, 4'b1000, 32'd63 << 24);
        rd(8'h10, 32'h0, "R4 clear eien ch63");

        // R5 pulses
        wr_pulse(8'h1C, 4'b0100, 32'd40 << 16, 1, 64'd1 << 40, "R5 start ch40");
        wr_pulse(8'h1C, 4'b1000, 32'd3 << 24, 2, 64'd1 << 3, "R5 done clear ch3");

        // R7 interrupt set, R6 write-one-to-clear
        ev_done((64'd1 << 2) | (64'd1 << 33));
        rd(8'h24, 32'h4, "R7 int lo");
        rd(8'h20, 32'h2, "R7 int hi");
        chk(4, 64'h2, "R7 int_irq");
        wr(8'h24, 4'hF, 32'h0);
        rd(8'h24, 32'h4, "R6 zero write keeps");
        wr(8'h24, 4'hF, 32'h4);
        rd(8'h24, 32'h0, "R6 one write clears");
        wr(8'h1C, 4'b0001, 32'd33);
        rd(8'h20, 32'h0, "R4 clear int ch33");
        chk(4, 64'h0, "R7 int_irq low");

        // R7 set wins over same-cycle clear
        @(negedge clk);
        done_int = 64'd1 << 7;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1C; bus_be = 4'b0001; bus_wdata = 32'd7;
        @(negedge clk);
        done_int = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
        rd(8'h24, 32'h80, "R7 set wins");
        wr(8'h24, 4'hF, 32'h80);

        // R8/R9 error with interrupt disabled
        ev_err(6'd9, 16'h0080);
        rd(8'h2C, 32'h0, "R8 disabled no flag");
        chk(4, 64'h0, "R8 no err_irq");
        rd(8'h04, 32'h8000_0980, "R9 capture");
        wr(8'h1C, 4'b0010, 32'd9 << 8);
        rd(8'h04, 32'h0, "R10 clear by command");

        // R8/R9/R10 with interrupt enabled
        wr(8'h18, 4'b0100, 32'd9 << 16);
        ev_err(6'd9, 16'hFFFF);
        rd(8'h04, 32'h8000_C9FF, "R9 cause bits");
        rd(8'h2C, 32'h200, "R8 flag set");
        chk(4, 64'h1, "R8 err_irq");
        ev_err(6'd10, 16'h0001);
        rd(8'h04, 32'h8000_C9FF, "R9 first kept");
        wr(8'h1C, 4'b0010, 32'd10 << 8);
        rd(8'h04, 32'h8000_C9FF, "R10 other channel");
        wr(8'h2C, 4'hF, 32'h200);
        rd(8'h2C, 32'h0, "R6 err w1c");
        rd(8'h04, 32'h0, "R10 clear by w1c");
        chk(4, 64'h0, "R8 err_irq low");

        // R11 hardware request status
        hw_req = 64'hDEAD_BEEF_0123_4567;
        rd(8'h30, 32'hDEAD_BEEF, "R11 hreq hi");
        wr(8'h34, 4'hF, 32'h0);
        rd(8'h34, 32'h0123_4567, "R11 write ignored");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule